// File: doc/BRIEF.md
# Shadowed Seconds Real-Time Counter with Alarms

This peripheral keeps a 32-bit seconds count and a milliseconds count, both advanced by a slow-clock strobe (`tick`, nominally a 32 kHz rate brought in as a one-cycle enable on the fast bus clock). The milliseconds count is paced by a fractional accumulator, so a step happens on average every `MS_MOD/MS_STEP` strobes. Counting is grouped into windows of `WIN` strobes. The values software sees are republished only at the end of each window. During that window's last strobe period a busy flag is raised, and writes made in that period are dropped.

Reading the milliseconds register also copies the published seconds into a shadow register. A reader that reads milliseconds and then the shadow therefore gets a pair from the same publication. Two seconds alarm comparators feed a write-one-to-clear status register. A per-source mask gates that register onto a level interrupt. The milliseconds-alarm value is stored and can be read back, and the two countdown status bits are present but never set.

The bus is a single-cycle register port. Reads are combinational on `bus_addr`, and a write takes effect at the clock edge at which `bus_sel` and `bus_wr` are both high.

Top module: `rtc_shadow_ctr`

## Requirements
- R1: After a synchronous reset, every readable register returns 0 and `irq` is 0.
- R2: Register 0x004 bit 0 (busy) reads 1 during exactly the last strobe period of each `WIN`-strobe window and 0 otherwise.
- R3: Registers 0x008 (seconds) and 0x010 (milliseconds) change only at the strobe that ends a window. At that strobe they take the live counts as they stood just before it.
- R4: Each strobe adds `MS_STEP` to an accumulator. When the sum reaches `MS_MOD`, the accumulator keeps the remainder and milliseconds advances by one. Milliseconds wraps from `MS_PER_SEC-1` to 0, and that wrap increments seconds.
- R5: A read of 0x010 loads the published seconds into the shadow register at 0x00C. The new shadow value is readable from the next cycle.
- R6: Any write made while busy reads 1 changes no register.
- R7: A write to 0x008 while not busy loads the live seconds count, and it takes priority over a same-cycle increment.
- R8: Alarm registers 0x014 and 0x018 hold 32-bit values. When the live seconds becomes equal to a nonzero alarm value, status bit 0 or bit 1 (respectively) is set one cycle later. An alarm holding 0 never sets its bit.
- R9: Writing to status (0x02C) clears each bit written as 1 and leaves each bit written as 0 unchanged. A set in the same cycle wins over the clear, and bits 2 to 4 always read 0.
- R10: `irq` is high exactly when some status bit and the same bit of the mask register (0x028, bits 4:0) are both 1.
- R11: Register 0x01C stores a 10-bit milliseconds-alarm value that reads back unchanged and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle slow-clock strobe |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `WIN=8`, `MS_STEP=1`, `MS_MOD=2` and `MS_PER_SEC=4`. With these values a simulated second lasts eight strobes, which is exactly one publication window. Milliseconds wraps, seconds carries and both alarms fire within a few dozen cycles. The strobe pattern changes between every cycle and every third cycle, so the busy period is seen both as one cycle and as several, and writes are aimed into it on purpose.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int MSEC_W  = 10;
    localparam int IRQ_SRC = 5;
    localparam int NUM_ALM = 2;

    localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSEC   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ALM0   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MSALM  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h2C;

    // one time stamp: whole seconds plus milliseconds within the second
    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [MSEC_W-1:0] msec;
    } stamp_t;

    // byte offset of the alarm comparator with index idx
    function automatic logic [ADDR_W-1:0] alarm_ofs(int idx);
        return OFS_ALM0 + ADDR_W'(4 * idx);
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int WIN        = 8,
    parameter int MS_STEP    = 1000,
    parameter int MS_MOD     = 32768,
    parameter int MS_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sec_load,
    input  logic [DATA_W-1:0] sec_value,
    output stamp_t            live,
    output stamp_t            pub,
    output logic              busy
);
    localparam int PH_W  = $clog2(WIN);
    localparam int ACC_W = $clog2(MS_MOD) + 1;

    logic [PH_W-1:0]  phase;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             ms_adv;
    logic             ms_wrap;

    always_comb begin
        acc_sum = acc + ACC_W'(MS_STEP);
        ms_adv  = tick && (acc_sum >= ACC_W'(MS_MOD));
        ms_wrap = ms_adv && (live.msec == MSEC_W'(MS_PER_SEC - 1));
        busy    = (phase == PH_W'(WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            acc   <= '0;
            live  <= '0;
            pub   <= '0;
        end else begin
            if (tick) begin
                acc   <= ms_adv ? acc_sum - ACC_W'(MS_MOD) : acc_sum;
                phase <= busy ? '0 : phase + PH_W'(1);
                if (busy) pub <= live;
            end
            if (ms_adv) live.msec <= ms_wrap ? '0 : live.msec + MSEC_W'(1);
            if (sec_load)     live.sec <= sec_value;
            else if (ms_wrap) live.sec <= live.sec + DATA_W'(1);
        end
    end

    // R4
    // msec_range_chk
    msec_range_chk: assert property (@(posedge clk) disable iff (rst)
        live.msec < MSEC_W'(MS_PER_SEC));

    // R2
    // busy_hold_chk
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

    // R3
    // pub_stable_chk
    pub_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && tick) |=> $stable(pub));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int N = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DATA_W-1:0]         sec,
    input  logic [N-1:0][DATA_W-1:0]  alarm,
    output logic [N-1:0]              hit
);
    logic [N-1:0] eq;
    logic [N-1:0] eq_q;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i]  = (alarm[i] != '0) && (sec == alarm[i]);
        assign hit[i] = eq[i] && !eq_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) eq_q <= '0;
        else     eq_q <= eq;
    end

endmodule

// File: rtl/rtc_shadow_ctr.sv
module rtc_shadow_ctr
    import rtc_pkg::*;
#(
    parameter int WIN        = 8,
    parameter int MS_STEP    = 1000,
    parameter int MS_MOD     = 32768,
    parameter int MS_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    stamp_t                           live;
    stamp_t                           pub;
    logic                             busy;
    logic                             wr_ok;
    logic                             ms_read;
    logic [DATA_W-1:0]                shadow;
    logic [NUM_ALM-1:0][DATA_W-1:0]   alm;
    logic [NUM_ALM-1:0]               hit;
    logic [MSEC_W-1:0]                msalm;
    logic [IRQ_SRC-1:0]               mask;
    logic [IRQ_SRC-1:0]               status;
    logic [IRQ_SRC-1:0]               clr;
    logic [IRQ_SRC-1:0]               set;

    assign wr_ok   = bus_sel && bus_wr && !busy;
    assign ms_read = bus_sel && !bus_wr && (bus_addr == OFS_MSEC);

    rtc_timebase #(
        .WIN(WIN), .MS_STEP(MS_STEP), .MS_MOD(MS_MOD), .MS_PER_SEC(MS_PER_SEC)
    ) u_time (
        .clk(clk), .rst(rst), .tick(tick),
        .sec_load(wr_ok && (bus_addr == OFS_SEC)),
        .sec_value(bus_wdata),
        .live(live), .pub(pub), .busy(busy)
    );

    rtc_alarm_match #(.N(NUM_ALM)) u_alarm (
        .clk(clk), .rst(rst), .sec(live.sec), .alarm(alm), .hit(hit)
    );

    always_comb begin
        set = '0;
        set[NUM_ALM-1:0] = hit;
        clr = (wr_ok && (bus_addr == OFS_STAT)) ? bus_wdata[IRQ_SRC-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            alm    <= '0;
            msalm  <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (ms_read) shadow <= pub.sec;
            status <= (status & ~clr) | set;
            if (wr_ok) begin
                for (int i = 0; i < NUM_ALM; i++)
                    if (bus_addr == alarm_ofs(i)) alm[i] <= bus_wdata;
                if (bus_addr == OFS_MSALM) msalm <= bus_wdata[MSEC_W-1:0];
                if (bus_addr == OFS_MASK)  mask  <= bus_wdata[IRQ_SRC-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_BUSY:        bus_rdata[0] = busy;
            OFS_SEC:         bus_rdata = pub.sec;
            OFS_SHADOW:      bus_rdata = shadow;
            OFS_MSEC:        bus_rdata[MSEC_W-1:0] = pub.msec;
            alarm_ofs(0):    bus_rdata = alm[0];
            alarm_ofs(1):    bus_rdata = alm[1];
            OFS_MSALM:       bus_rdata[MSEC_W-1:0] = msalm;
            OFS_MASK:        bus_rdata[IRQ_SRC-1:0] = mask;
            OFS_STAT:        bus_rdata[IRQ_SRC-1:0] = status;
            default:         bus_rdata = '0;
        endcase
    end

    assign irq = |(status & mask);

    // R5
    // shadow_cap_chk
    shadow_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ms_read |=> (shadow == $past(pub.sec)));

    // R6
    // busy_write_chk
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_sel && bus_wr) |=> ($stable(mask) && $stable(alm) && $stable(msalm)));

    // R8
    // alarm_src_chk
    alarm_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past((alm[0] != '0) && (live.sec == alm[0])));

    // R9
    // cdn_zero_chk
    cdn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status[IRQ_SRC-1:NUM_ALM+1] == '0);

    // R10
    // irq_hold_chk
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_sel && bus_wr && (bus_addr == OFS_MASK || bus_addr == OFS_STAT))) |=> irq);

endmodule

// File: tb/tb_rtc_shadow_ctr.sv
`timescale 1ns/1ps
module tb_rtc_shadow_ctr;
    localparam int WIN = 8, MS_STEP = 1, MS_MOD = 2, MS_PER_SEC = 4;
    localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10,
                           A_AL0 = 8'h14, A_AL1 = 8'h18, A_MSA = 8'h1C, A_MASK = 8'h28,
                           A_STAT = 8'h2C;

    logic        clk = 0, rst = 1, tick = 0, bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0, tick_div = 0, cyc = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned m_phase, m_acc, m_ms, m_sec, m_pub_sec, m_pub_ms, m_shadow, m_msalm, m_mask, m_stat;
    int unsigned m_alm[2];
    bit          m_prev[2];

    always #2 clk = ~clk;

    rtc_shadow_ctr #(.WIN(WIN), .MS_STEP(MS_STEP), .MS_MOD(MS_MOD), .MS_PER_SEC(MS_PER_SEC)) dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int unsigned model_rd(logic [7:0] a);
        case (a)
            A_BUSY: return (m_phase == WIN - 1) ? 1 : 0;
            A_SEC:  return m_pub_sec;
            A_SHD:  return m_shadow;
            A_MS:   return m_pub_ms;
            A_AL0:  return m_alm[0];
            A_AL1:  return m_alm[1];
            A_MSA:  return m_msalm;
            A_MASK: return m_mask;
            A_STAT: return m_stat;
            default: return 0;
        endcase
    endfunction

    // reference model, one step per clock
    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_acc = 0; m_ms = 0; m_sec = 0; m_pub_sec = 0; m_pub_ms = 0;
            m_shadow = 0; m_msalm = 0; m_mask = 0; m_stat = 0;
            m_alm[0] = 0; m_alm[1] = 0; m_prev[0] = 0; m_prev[1] = 0;
        end else begin
            bit busy_now, wr, carry, hitm;
            int unsigned setb;
            busy_now = (m_phase == WIN - 1);
            wr = bus_sel && bus_wr && !busy_now;
            carry = 0; setb = 0;
            for (int i = 0; i < 2; i++) begin
                hitm = (m_alm[i] != 0) && (m_sec == m_alm[i]);
                if (hitm && !m_prev[i]) setb |= (1 << i);
                m_prev[i] = hitm;
            end
            if (bus_sel && !bus_wr && bus_addr == A_MS) m_shadow = m_pub_sec;
            if (tick) begin
                if (busy_now) begin m_pub_sec = m_sec; m_pub_ms = m_ms; end
                m_phase = busy_now ? 0 : m_phase + 1;
                m_acc += MS_STEP;
                if (m_acc >= MS_MOD) begin
                    m_acc -= MS_MOD;
                    if (m_ms == MS_PER_SEC - 1) begin m_ms = 0; carry = 1; end
                    else m_ms++;
                end
            end
            m_stat = (m_stat & ~((wr && bus_addr == A_STAT) ? (bus_wdata & 32'h1f) : 0)) | setb;
            if (wr && bus_addr == A_SEC) m_sec = bus_wdata;
            else if (carry) m_sec++;
            if (wr && bus_addr == A_AL0)  m_alm[0] = bus_wdata;
            if (wr && bus_addr == A_AL1)  m_alm[1] = bus_wdata;
            if (wr && bus_addr == A_MSA)  m_msalm = bus_wdata & 32'h3ff;
            if (wr && bus_addr == A_MASK) m_mask = bus_wdata & 32'h1f;
        end
    end

    // strobe generator
    always @(negedge clk) begin
        cyc++;
        tick = (tick_div > 0) && (cyc % tick_div == 0);
    end

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk(irq === ((m_stat & m_mask) != 0), "R10 irq vs model", irq, (m_stat & m_mask) != 0);
            chk(bus_rdata === model_rd(bus_addr), "R3 rdata vs model", bus_rdata, model_rd(bus_addr));
        end
    end

    // tasks assume they start at a falling edge
    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic wr_raw(logic [7:0] a, logic [31:0] v);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        while (m_phase == WIN - 1) @(negedge clk);
        wr_raw(a, v);
    endtask

    task automatic wait_busy();
        while (m_phase != WIN - 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finished = 1;
        summary();
    end

    initial begin
        logic [31:0] d, exp;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        begin
            logic [7:0] addrs [9] = '{A_BUSY, A_SEC, A_SHD, A_MS, A_AL0, A_AL1, A_MSA, A_MASK, A_STAT};
            foreach (addrs[k]) begin
                rd(addrs[k], d);
                chk(d == 0, "R1 reset value", d, 0);
            end
        end
        chk(irq == 0, "R1 irq after reset", irq, 0);

        // R2 busy exactly in the last strobe period
        tick_div = 1;
        @(negedge clk);
        wait_busy();
        rd(A_BUSY, d); chk(d == 1, "R2 busy set", d, 1);
        rd(A_BUSY, d); chk(d == 0, "R2 busy clear", d, 0);

        // R4 counts advance: 5 windows = 5 s with these parameters
        repeat (40) @(negedge clk);
        rd(A_SEC, d); chk(d >= 4 && d <= 6, "R4 seconds advance", d, 5);

        // R3 / R5 coherent pair through the shadow
        exp = m_pub_sec;
        rd(A_MS, d);
        rd(A_SHD, d); chk(d == exp, "R5 shadow capture", d, exp);

        // R7 load seconds
        wr(A_SEC, 32'd1000);
        repeat (2 * WIN) @(negedge clk);
        rd(A_SEC, d); chk(d >= 1000 && d <= 1002, "R7 seconds load", d, 1001);

        // R6 writes in busy period dropped
        wait_busy();
        wr_raw(A_MASK, 32'h1f);
        rd(A_MASK, d); chk(d == 0, "R6 mask write ignored", d, 0);
        wait_busy();
        wr_raw(A_AL1, 32'h1234);
        rd(A_AL1, d); chk(d == 0, "R6 alarm write ignored", d, 0);

        // R8 alarm0 fires, alarm1 at zero stays quiet
        wr(A_AL0, m_sec + 2);
        wr(A_MASK, 32'h1);
        repeat (40) @(negedge clk);
        rd(A_STAT, d); chk(d == 1, "R8 alarm0 status", d, 1);
        chk(irq == 1, "R10 irq asserted", irq, 1);

        // R10 mask gating
        wr(A_MASK, 32'h0);
        chk(irq == 0, "R10 irq masked", irq, 0);
        wr(A_MASK, 32'h1);
        chk(irq == 1, "R10 irq unmasked", irq, 1);

        // R9 write-one-to-clear
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk(d == 1, "R9 zero write keeps", d, 1);
        wr(A_STAT, 32'hffff_ffff);
        rd(A_STAT, d); chk(d == 0, "R9 one clears", d, 0);
        chk(irq == 0, "R9 irq after clear", irq, 0);

        // R11 milliseconds alarm storage only
        wr(A_MSA, 32'hffff_ffff);
        rd(A_MSA, d); chk(d == 32'h3ff, "R11 msalm readback", d, 32'h3ff);
        repeat (20) @(negedge clk);
        rd(A_STAT, d); chk((d & 32'h1c) == 0, "R11 no msec status", d, 0);

        // R8 alarm1 with slower strobes
        tick_div = 3;
        wr(A_AL1, m_sec + 1);
        wr(A_MASK, 32'h2);
        repeat (120) @(negedge clk);
        rd(A_STAT, d); chk((d & 2) == 2, "R8 alarm1 status", d, 2);
        chk(irq == 1, "R10 irq from alarm1", irq, 1);

        // long run under model comparison with a mix of accesses
        for (int n = 0; n < 60; n++) begin
            rd(A_MS, d);
            rd(A_SHD, d);
            if (n % 10 == 0) wr(A_STAT, 32'h3);
            repeat (5) @(negedge clk);
        end
        finished = 1;
        summary();
    end
endmodule